// File: doc/BRIEF.md
# Modulation-Line Mode Controller for an Antenna Driver Front End

This block sits between a contactless reader's analog front end and its host side. It decides when the antenna drivers are on, when the reader sleeps and wakes, and where demodulated data and the serial bus signals are routed. Two mode-select pins choose one of three configurations. In the two-wire bus configuration a separate modulation line carries the write modulation and the power-down command, and demodulated data leave on the open-drain bus. In the microcontroller configuration the host drives the modulation line and a sleep pin directly, reads data on a logic output, and uses the bus as a plain transmit and receive pair.

In both of these configurations a high modulation level switches the drivers on and a low level switches them off. The modulation is echoed on the data path, so a host can diagnose an open or shorted antenna. After reset and after every wake-up the block waits for a clock-settled flag before it accepts any command. The single-wire selection is handled by a separate controller, and this block stays quiet there.

Top module: `modctl_top`

## Requirements
- R1: After reset the block is waking: `drv_en`=1, `standby`=0, and `bus_drive`, `data_out` and `rx_mon` are 0 (in the two-wire configuration). While waking and `clk_ok`=0, changes on `mod_in` and on the mode pins have no effect on `drv_en`. The block starts operating on the first clock edge that sees `clk_ok`=1.
- R2: While operating in the two-wire (`cfg_sel`=01) or microcontroller (`cfg_sel[1]`=1) configuration, `drv_en` equals the `mod_in` level sampled on the previous clock edge.
- R3: In the two-wire configuration while operating, `bus_drive` (1 = pull the bus dominant low) is the inverse of `demod_in` when `mod_in`=1. It is 1 when `mod_in`=0, which echoes the modulation.
- R4: In the microcontroller configuration while operating, `data_out` equals `demod_in` when `mod_in`=1 and is 0 when `mod_in`=0.
- R5: In the two-wire configuration, `mod_in` sampled low on LOW_CYC consecutive clock edges starts an acknowledge. A low run of LOW_CYC-1 edges followed by a high does not start one.
- R6: The acknowledge holds `bus_drive`=1 for exactly ACK_CYC clock cycles, whatever `mod_in` does. It then enters standby with `standby`=1, `drv_en`=0 and `bus_drive`=0.
- R7: Two-wire standby is left only on a rising edge of `mod_in`. A steady high level keeps the block in standby. On leaving, `standby` drops and the block waits for `clk_ok` as in R1.
- R8: In the two-wire configuration `data_out` and `rx_mon` are always 0, and `tx_in` has no effect on `bus_drive`.
- R9: In the microcontroller configuration, `cfg_sel[0]`=0 while operating gives `standby`=1 after the next edge. `cfg_sel[0]`=1 in standby clears `standby` after the next edge and starts a wake-up.
- R10: In microcontroller standby, `drv_en` keeps the value it had on entry, `data_out`=0, `bus_drive`=0 whatever `tx_in` is, and `rx_mon` equals `bus_rx`.
- R11: In the microcontroller configuration while operating, `bus_drive` equals `tx_in` and `rx_mon` equals `bus_rx` (1 = bus high).
- R12: With `cfg_sel`=00, `bus_drive`, `data_out`, `rx_mon` and `standby` stay 0, and `drv_en` does not change, even after a long low on `mod_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 2 | Mode pins: bit 1 selects microcontroller, bit 0 selects two-wire or is the sleep pin |
| mod_in | input | 1 | Modulation and command line |
| tx_in | input | 1 | Host transmit request for the bus (microcontroller configuration) |
| bus_rx | input | 1 | Received bus level, 1 = high/recessive |
| demod_in | input | 1 | Demodulated tag data |
| clk_ok | input | 1 | Oscillator settled flag |
| drv_en | output | 1 | Antenna driver enable |
| bus_drive | output | 1 | Bus pull-down, 1 = dominant low |
| data_out | output | 1 | Logic data output |
| rx_mon | output | 1 | Bus receive monitor |
| standby | output | 1 | Block is in standby |

## Verification
The modulation line is driven with short pulses, with low runs that stop one edge short of the power-down threshold, and with a full-length low followed by an early high. These runs separate the echo path from the start of the acknowledge and show that the acknowledge length is fixed. Wake-up is tried with a steady high and with a true rising edge, both with the clock-settled flag held off, to show that only the edge wakes the block and that no command is taken before the flag. The microcontroller runs change transmit, receive and modulation inside standby, which shows the driver freeze and the gating. The single-wire selection is checked to stay silent.

// File: rtl/modctl_pkg.sv
package modctl_pkg;

  typedef enum logic [1:0] {
    ST_WAKE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ACK  = 2'd2,
    ST_STBY = 2'd3
  } mc_state_e;

  typedef enum logic [1:0] {
    CFG_SINGLE = 2'd0,
    CFG_TWO    = 2'd1,
    CFG_MCU    = 2'd2
  } mc_cfg_e;

  // mode pin decode: bit 1 wins, bit 0 picks two-wire
  function automatic mc_cfg_e decode_cfg(input logic [1:0] sel);
    if (sel[1])      return CFG_MCU;
    else if (sel[0]) return CFG_TWO;
    else             return CFG_SINGLE;
  endfunction

  // data seen on the data path: tag data while carrier is on, low echo otherwise
  function automatic logic echo_bit(input logic mod, input logic demod);
    return mod & demod;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/run_timer.sv
module run_timer
  import modctl_pkg::*;
#(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // done on the LIMIT-th consecutive cycle with run high
  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (done)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mc_fsm.sv
module mc_fsm
  import modctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mc_cfg_e   cfg,
  input  logic      sleep_pin,
  input  logic      mod_in,
  input  logic      clk_ok,
  input  logic      long_low_done,
  input  logic      ack_done,
  output mc_state_e state
);
  mc_state_e st_q, st_d;
  logic      mod_prev_q;
  logic      mod_rise;

  assign mod_rise = mod_in && !mod_prev_q;
  assign state    = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAKE: if (clk_ok) st_d = ST_RUN;
      ST_RUN: begin
        if (cfg == CFG_TWO && long_low_done)  st_d = ST_ACK;
        else if (cfg == CFG_MCU && !sleep_pin) st_d = ST_STBY;
      end
      ST_ACK:  if (ack_done) st_d = ST_STBY;
      ST_STBY: begin
        if (cfg == CFG_TWO && mod_rise)      st_d = ST_WAKE;
        else if (cfg == CFG_MCU && sleep_pin) st_d = ST_WAKE;
      end
      default: st_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_WAKE;
      mod_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      mod_prev_q <= mod_in;
    end
  end
endmodule

// File: rtl/pin_router.sv
module pin_router
  import modctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mc_state_e state,
  input  mc_cfg_e   cfg,
  input  logic      mod_in,
  input  logic      tx_in,
  input  logic      bus_rx,
  input  logic      demod_in,
  output logic      drv_en,
  output logic      bus_drive,
  output logic      data_out,
  output logic      rx_mon,
  output logic      standby
);
  logic drv_q;

  assign drv_en = drv_q;

  // driver enable: follows the line while running, forced off around
  // two-wire sleep, frozen otherwise (wake and host-controlled sleep)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b1;
    end else begin
      unique case (state)
        ST_RUN:  if (cfg != CFG_SINGLE) drv_q <= mod_in;
        ST_ACK:  drv_q <= 1'b0;
        ST_STBY: if (cfg == CFG_TWO) drv_q <= 1'b0;
        default: drv_q <= drv_q;
      endcase
    end
  end

  always_comb begin
    bus_drive = 1'b0;
    data_out  = 1'b0;
    rx_mon    = 1'b0;
    standby   = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (cfg == CFG_TWO) begin
          bus_drive = !echo_bit(mod_in, demod_in);
        end else if (cfg == CFG_MCU) begin
          data_out  = echo_bit(mod_in, demod_in);
          bus_drive = tx_in;
          rx_mon    = bus_rx;
        end
      end
      ST_ACK:  bus_drive = 1'b1;
      ST_STBY: begin
        standby = 1'b1;
        if (cfg == CFG_MCU) rx_mon = bus_rx;
      end
      default: begin
        if (cfg == CFG_MCU) rx_mon = bus_rx;
      end
    endcase
  end
endmodule

// File: rtl/modctl_top.sv
module modctl_top
  import modctl_pkg::*;
#(
  parameter int unsigned LOW_CYC = 16256,
  parameter int unsigned ACK_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_sel,
  input  logic       mod_in,
  input  logic       tx_in,
  input  logic       bus_rx,
  input  logic       demod_in,
  input  logic       clk_ok,
  output logic       drv_en,
  output logic       bus_drive,
  output logic       data_out,
  output logic       rx_mon,
  output logic       standby
);
  mc_cfg_e   cfg;
  mc_state_e state;
  logic      long_low_run;
  logic      long_low_done;
  logic      ack_done;

  // named internal events, observed by the bound checker
  logic is_wake, is_run, is_ack, is_stby;

  assign cfg          = decode_cfg(cfg_sel);
  assign is_wake      = (state == ST_WAKE);
  assign is_run       = (state == ST_RUN);
  assign is_ack       = (state == ST_ACK);
  assign is_stby      = (state == ST_STBY);
  assign long_low_run = is_run && (cfg == CFG_TWO) && !mod_in;

  run_timer #(.LIMIT(LOW_CYC)) low_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (long_low_run),
    .done  (long_low_done)
  );

  run_timer #(.LIMIT(ACK_CYC)) ack_tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (is_ack),
    .done  (ack_done)
  );

  mc_fsm fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg           (cfg),
    .sleep_pin     (cfg_sel[0]),
    .mod_in        (mod_in),
    .clk_ok        (clk_ok),
    .long_low_done (long_low_done),
    .ack_done      (ack_done),
    .state         (state)
  );

  pin_router rt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .cfg       (cfg),
    .mod_in    (mod_in),
    .tx_in     (tx_in),
    .bus_rx    (bus_rx),
    .demod_in  (demod_in),
    .drv_en    (drv_en),
    .bus_drive (bus_drive),
    .data_out  (data_out),
    .rx_mon    (rx_mon),
    .standby   (standby)
  );
endmodule

// File: rtl/modctl_checker.sv
module modctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_sel,
  input logic       mod_in,
  input logic       clk_ok,
  input logic       drv_en,
  input logic       bus_drive,
  input logic       data_out,
  input logic       rx_mon,
  input logic       is_wake,
  input logic       is_run,
  input logic       is_ack,
  input logic       is_stby,
  input logic       long_low_done
);
  a_r1_wait_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wake && !clk_ok) |=> !is_run);

  a_r2_drv_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (is_run && cfg_sel != 2'b00) |=> (drv_en == $past(mod_in)));

  a_r5_ack_start: assert property (@(posedge clk) disable iff (!rst_n)
    long_low_done |=> is_ack);

  a_r6_ack_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    is_ack |-> bus_drive);

  a_r9_host_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (is_run && cfg_sel == 2'b10) |=> is_stby);

  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stby && $past(is_stby) && cfg_sel[1]) |-> $stable(drv_en));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_stby |-> (!data_out && !bus_drive));

  a_r12_single_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'b00) |-> (!bus_drive && !data_out && !rx_mon));
endmodule

bind modctl_top modctl_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_sel       (cfg_sel),
  .mod_in        (mod_in),
  .clk_ok        (clk_ok),
  .drv_en        (drv_en),
  .bus_drive     (bus_drive),
  .data_out      (data_out),
  .rx_mon        (rx_mon),
  .is_wake       (is_wake),
  .is_run        (is_run),
  .is_ack        (is_ack),
  .is_stby       (is_stby),
  .long_low_done (long_low_done)
);

// File: tb/modctl_top_tb_top.sv
`timescale 1ns/1ps
module modctl_top_tb_top;
  localparam int unsigned LOW_T = 60;
  localparam int unsigned ACK_T = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_sel = 2'b01;
  logic       mod_in = 1'b1;
  logic       tx_in = 1'b0;
  logic       bus_rx = 1'b1;
  logic       demod_in = 1'b0;
  logic       clk_ok = 1'b0;
  logic       drv_en, bus_drive, data_out, rx_mon, standby;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  modctl_top #(.LOW_CYC(LOW_T), .ACK_CYC(ACK_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .mod_in(mod_in),
    .tx_in(tx_in), .bus_rx(bus_rx), .demod_in(demod_in), .clk_ok(clk_ok),
    .drv_en(drv_en), .bus_drive(bus_drive), .data_out(data_out),
    .rx_mon(rx_mon), .standby(standby)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #4;
    end
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset_wake;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(drv_en, 1'b1, "R1", "drv_en after reset");
    chk(standby, 1'b0, "R1", "standby after reset");
    chk(bus_drive, 1'b0, "R1", "bus_drive after reset");
    chk(data_out, 1'b0, "R1", "data_out after reset");
    chk(rx_mon, 1'b0, "R1", "rx_mon after reset");
    mod_in = 1'b0;
    tick(5);
    chk(drv_en, 1'b1, "R1", "drv_en ignores mod before clk_ok");
    chk(bus_drive, 1'b0, "R1", "no echo before clk_ok");
    clk_ok = 1'b1;
    tick(2);
    chk(drv_en, 1'b0, "R2", "drv_en follows mod after settle");
  endtask

  task automatic t_two_echo;
    mod_in = 1'b1; demod_in = 1'b1; tx_in = 1'b1; bus_rx = 1'b0;
    #1;
    chk(bus_drive, 1'b0, "R3", "bus released for demod 1");
    chk(data_out, 1'b0, "R8", "data_out low in two-wire");
    chk(rx_mon, 1'b0, "R8", "rx_mon low in two-wire");
    demod_in = 1'b0;
    #1;
    chk(bus_drive, 1'b1, "R3", "bus dominant for demod 0");
    tick(1);
    chk(drv_en, 1'b1, "R2", "drv_en on after mod high");
    mod_in = 1'b0; demod_in = 1'b1;
    #1;
    chk(bus_drive, 1'b1, "R3", "mod low echoed as dominant");
    tick(1);
    chk(drv_en, 1'b0, "R2", "drv_en off after mod low");
    mod_in = 1'b1; tx_in = 1'b0;
    tick(1);
  endtask

  task automatic t_near_miss;
    for (int k = 0; k < 2; k++) begin
      demod_in = 1'b1;
      mod_in = 1'b0;
      tick(LOW_T - 1);
      mod_in = 1'b1;
      tick(1);
      chk(bus_drive, 1'b0, "R5", "short low run gives no acknowledge");
      chk(standby, 1'b0, "R5", "short low run gives no standby");
    end
  endtask

  task automatic t_two_standby;
    demod_in = 1'b1;
    mod_in = 1'b0;
    tick(LOW_T);
    mod_in = 1'b1;
    #1;
    chk(bus_drive, 1'b1, "R6", "acknowledge holds bus despite mod high");
    chk(standby, 1'b0, "R6", "not yet standby at ack start");
    tick(ACK_T - 1);
    chk(bus_drive, 1'b1, "R6", "ack still on at last cycle");
    chk(standby, 1'b0, "R6", "standby not early");
    tick(1);
    chk(standby, 1'b1, "R6", "standby after ack");
    chk(bus_drive, 1'b0, "R6", "bus released in standby");
    chk(drv_en, 1'b0, "R6", "drivers off in standby");
    tick(3);
    chk(standby, 1'b1, "R7", "steady high does not wake");
    mod_in = 1'b0;
    clk_ok = 1'b0;
    tick(1);
    mod_in = 1'b1;
    tick(1);
    chk(standby, 1'b0, "R7", "rising edge wakes");
    tick(3);
    chk(drv_en, 1'b0, "R7", "drivers held until clk_ok");
    chk(bus_drive, 1'b0, "R7", "bus quiet while waking");
    clk_ok = 1'b1;
    tick(2);
    chk(drv_en, 1'b1, "R7", "read mode after settle");
    chk(bus_drive, 1'b0, "R3", "read data routed after wake");
  endtask

  task automatic t_mcu;
    cfg_sel = 2'b11; mod_in = 1'b1; demod_in = 1'b1; tx_in = 1'b0; bus_rx = 1'b1;
    #1;
    chk(data_out, 1'b1, "R4", "data_out carries demod");
    chk(rx_mon, 1'b1, "R11", "rx_mon high");
    chk(bus_drive, 1'b0, "R11", "tx low releases bus");
    tx_in = 1'b1;
    #1;
    chk(bus_drive, 1'b1, "R11", "tx high pulls bus");
    bus_rx = 1'b0;
    #1;
    chk(rx_mon, 1'b0, "R11", "rx_mon follows bus low");
    demod_in = 1'b0;
    #1;
    chk(data_out, 1'b0, "R4", "data_out demod 0");
    mod_in = 1'b0; demod_in = 1'b1;
    #1;
    chk(data_out, 1'b0, "R4", "mod low echoed as 0");
    tick(1);
    chk(drv_en, 1'b0, "R2", "mcu drivers off");
    mod_in = 1'b1;
    tick(1);
    chk(drv_en, 1'b1, "R2", "mcu drivers on");
    cfg_sel = 2'b10;
    tick(1);
    chk(standby, 1'b1, "R9", "sleep pin low enters standby");
    mod_in = 1'b0;
    tick(2);
    chk(drv_en, 1'b1, "R10", "drivers frozen in standby");
    mod_in = 1'b1; demod_in = 1'b1; tx_in = 1'b1; bus_rx = 1'b1;
    #1;
    chk(data_out, 1'b0, "R10", "data_out low in standby");
    chk(bus_drive, 1'b0, "R10", "tx disabled in standby");
    chk(rx_mon, 1'b1, "R10", "rx_mon follows bus high");
    bus_rx = 1'b0;
    #1;
    chk(rx_mon, 1'b0, "R10", "rx_mon follows bus low");
    clk_ok = 1'b0; cfg_sel = 2'b11; mod_in = 1'b0;
    tick(1);
    chk(standby, 1'b0, "R9", "sleep pin high wakes");
    tick(2);
    chk(drv_en, 1'b1, "R1", "no command before clk_ok");
    clk_ok = 1'b1;
    tick(2);
    chk(drv_en, 1'b0, "R2", "mcu follows mod after wake");
    tx_in = 1'b0;
  endtask

  task automatic t_single;
    cfg_sel = 2'b00; mod_in = 1'b1; demod_in = 1'b1; tx_in = 1'b1; bus_rx = 1'b1;
    #1;
    chk(bus_drive, 1'b0, "R12", "bus quiet");
    chk(data_out, 1'b0, "R12", "data quiet");
    chk(rx_mon, 1'b0, "R12", "rx quiet");
    tick(2);
    chk(drv_en, 1'b0, "R12", "drv_en unchanged by mod high");
    mod_in = 1'b0;
    tick(LOW_T + ACK_T + 2);
    chk(standby, 1'b0, "R12", "long low gives no standby");
    chk(bus_drive, 1'b0, "R12", "long low gives no ack");
  endtask

  initial begin
    t_reset_wake;
    t_two_echo;
    t_near_miss;
    t_two_standby;
    t_mcu;
    t_single;
    done_flag = 1;
    report;
  end

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1-watchdog all: actual timeout expected completion");
      report;
    end
  end
endmodule